// File: doc/BRIEF.md
# SPI Access Pacing and Wake Sequencer

This block stands between a client that wants to run transactions on an SPI slave and the engine that moves the serial data. The slave has two weaknesses. It loses data when a new transaction starts too soon after the previous one ended. It also falls asleep after a long idle stretch and misses the first bits sent to it. The sequencer holds each request back until both hazards have been handled, and only then gives the client a grant.

A prescaler derives a millisecond count from the system clock. When a transaction finishes, the sequencer stores the time. When a request arrives, it first waits out whatever is left of the minimum gap. It then checks whether the present time still lies strictly between the last finish time and the sleep deadline. If it does not, the sequencer drives a chip-select-only wake pulse and then waits a fixed startup time. The sleep deadline is moved forward on every grant. A busy flag covers the whole period from acceptance to the engine's done report.

Top module: `spi_pace_wake`

## Requirements
- R1: After reset, `grant_o`, `busy_o` and `cs_wake_o` are low. The last-finish time and the sleep deadline both equal the reset time, so the first request always causes a wake.
- R2: One millisecond is `CLK_PER_MS` clock cycles, counted from reset release. A grant is not given until the millisecond count minus the last-finish time is at least `GAP_MS`. When no wake is needed, the grant comes in the cycle after that condition first holds.
- R3: A wake is performed exactly when the millisecond count, taken in the cycle the gap is satisfied, is not strictly greater than the last-finish time or not strictly less than the sleep deadline.
- R4: A wake drives `cs_wake_o` high for exactly `PULSE_MS*CLK_PER_MS` consecutive cycles. The pulse begins in the cycle after the gap is satisfied and never overlaps a grant.
- R5: After a wake pulse ends, `grant_o` rises exactly `STARTUP_MS*CLK_PER_MS` cycles later.
- R6: Every grant, with or without a wake, sets the sleep deadline to the millisecond count of the cycle before the grant plus `SLEEP_MS`.
- R7: `grant_o` is a single-cycle pulse, given exactly once for each accepted request.
- R8: `busy_o` goes high in the cycle after a request is accepted. It stays high until the cycle after `done_i` is seen following the grant, and then it drops.
- R9: The last-finish time is taken only from a `done_i` that follows a grant. A `done_i` while idle changes neither `busy_o` nor the timing of the next grant.
- R10: `req_i` is sampled only while idle. A request held high through the gap and wake waits stays pending and produces one grant, with no second grant once it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Client request for a transaction slot |
| done_i | input | 1 | Transaction engine reports end of transfer, including an error ending |
| grant_o | output | 1 | One-cycle permission to start the transaction |
| busy_o | output | 1 | High from acceptance until done is reported |
| cs_wake_o | output | 1 | Chip-select override; high drives the slave select active with no clocking |

## Verification
A request sampled at one edge puts the block in its gap wait at that edge. The grant then rises one cycle after the first cycle in which the gap holds. When a wake is needed, it rises `(PULSE_MS+STARTUP_MS)*CLK_PER_MS` cycles after that. The bench keeps a count of edges since reset release, so the millisecond count at any edge is that count divided by `CLK_PER_MS`. From this it predicts the exact edge of the grant, the start and length of the wake pulse, and the new deadline. It also predicts the fall of `busy_o` one edge after done. Every output is sampled on the falling clock edge and compared against the predicted edge number, never against a window.

// File: rtl/spi_pace_pkg.sv
package spi_pace_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_PULSE,
        ST_START,
        ST_GRANT,
        ST_XFER
    } pace_state_e;

endpackage

// File: rtl/pace_ms_base.sv
module pace_ms_base #(
    parameter int CLK_PER_MS = 100000,
    parameter int TIME_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now_o
);
    localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_MS - 1);

    typedef struct packed {
        logic [PW-1:0]     pre;
        logic [TIME_W-1:0] now;
    } base_t;

    base_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.pre == PRE_LAST) begin
            nxt_d.pre = '0;
            nxt_d.now = cur_q.now + 1'b1;
        end else begin
            nxt_d.pre = cur_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign now_o = cur_q.now;

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.pre <= PRE_LAST); // R2

endmodule

// File: rtl/pace_cycle_timer.sv
module pace_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = load_val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/spi_pace_wake.sv
module spi_pace_wake
    import spi_pace_pkg::*;
#(
    parameter int CLK_PER_MS = 100000,
    parameter int GAP_MS     = 2,
    parameter int SLEEP_MS   = 1000,
    parameter int PULSE_MS   = 1,
    parameter int STARTUP_MS = 60,
    parameter int TIME_W     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic done_i,
    output logic grant_o,
    output logic busy_o,
    output logic cs_wake_o
);
    localparam int PULSE_CYC   = PULSE_MS * CLK_PER_MS;
    localparam int STARTUP_CYC = STARTUP_MS * CLK_PER_MS;
    localparam int MAX_CYC     = (PULSE_CYC > STARTUP_CYC) ? PULSE_CYC : STARTUP_CYC;
    localparam int CNT_W       = $clog2(MAX_CYC + 1);
    localparam logic [TIME_W-1:0] GAP_T   = TIME_W'(GAP_MS);
    localparam logic [TIME_W-1:0] SLEEP_T = TIME_W'(SLEEP_MS);
    localparam logic [CNT_W-1:0]  PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0]  START_LD = CNT_W'(STARTUP_CYC - 1);

    typedef struct packed {
        pace_state_e       st;
        logic [TIME_W-1:0] last;
        logic [TIME_W-1:0] dl;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic [TIME_W-1:0] now_ms;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;

    logic [TIME_W-1:0]        elapsed;
    logic signed [TIME_W-1:0] past_last;
    logic signed [TIME_W-1:0] to_deadline;
    logic                     gap_ok;
    logic                     asleep;

    pace_ms_base #(
        .CLK_PER_MS (CLK_PER_MS),
        .TIME_W     (TIME_W)
    ) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .now_o (now_ms)
    );

    pace_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        elapsed     = now_ms - cur_q.last;
        past_last   = $signed(now_ms - cur_q.last);
        to_deadline = $signed(cur_q.dl - now_ms);
        gap_ok      = (elapsed >= GAP_T);
        asleep      = !((past_last > 0) && (to_deadline > 0));
    end

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (req_i) nxt_d.st = ST_GAP;
            end
            ST_GAP: begin
                if (gap_ok) begin
                    if (asleep) begin
                        nxt_d.st = ST_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = PULSE_LD;
                    end else begin
                        nxt_d.st = ST_GRANT;
                        nxt_d.dl = now_ms + SLEEP_T;
                    end
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    nxt_d.st = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = START_LD;
                end
            end
            ST_START: begin
                if (tmr_zero) begin
                    nxt_d.st = ST_GRANT;
                    nxt_d.dl = now_ms + SLEEP_T;
                end
            end
            ST_GRANT: begin
                nxt_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (done_i) begin
                    nxt_d.st   = ST_IDLE;
                    nxt_d.last = now_ms;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.last <= '0;
            cur_q.dl   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign grant_o   = (cur_q.st == ST_GRANT);
    assign busy_o    = (cur_q.st != ST_IDLE);
    assign cs_wake_o = (cur_q.st == ST_PULSE);

    AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> !grant_o); // R7
    AST_WAKE_NOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_wake_o |-> (!grant_o && busy_o)); // R4
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> busy_o); // R8
    AST_GAP_BEFORE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> ((now_ms - cur_q.last) >= GAP_T)); // R2
    AST_GAP_BEFORE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_wake_o) |-> ((now_ms - cur_q.last) >= GAP_T)); // R3
    AST_DEADLINE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> (cur_q.dl == TIME_W'($past(now_ms) + SLEEP_T))); // R6
    AST_IDLE_KEEPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o) |=> (cur_q.last == $past(cur_q.last))); // R9

endmodule

// File: tb/spi_pace_wake_test.sv
module spi_pace_wake_test;
    localparam int CPM   = 4;
    localparam int GAP   = 2;
    localparam int SLEEP = 20;
    localparam int PUL   = 1;
    localparam int STRT  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic done = 1'b0;
    logic grant, busy, cs_wake;

    int n = 0;
    int n_chk = 0;
    int n_fail = 0;
    int last_ms = 0;
    int dead_ms = 0;
    bit finished = 1'b0;

    spi_pace_wake #(
        .CLK_PER_MS (CPM),
        .GAP_MS     (GAP),
        .SLEEP_MS   (SLEEP),
        .PULSE_MS   (PUL),
        .STARTUP_MS (STRT),
        .TIME_W     (16)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .done_i    (done),
        .grant_o   (grant),
        .busy_o    (busy),
        .cs_wake_o (cs_wake)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) n <= n + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, n);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // One transaction: idle gap, request, grant, transfer, done.
    task automatic txn(input int idle_cyc, input int xfer_cyc, input bit hold_req);
        int e, m, now_g, exp_g, exp_len, cs_len, cs_first, guard;
        bit wake;
        repeat (idle_cyc) @(negedge clk);
        req = 1'b1;
        e = n + 1;
        @(negedge clk);
        if (!hold_req) req = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        m = e;
        while ((m / CPM) - last_ms < GAP) m++;
        now_g   = m / CPM;
        wake    = !((now_g > last_ms) && (now_g < dead_ms));
        exp_g   = wake ? m + 1 + (PUL + STRT) * CPM : m + 1;
        exp_len = wake ? PUL * CPM : 0;
        cs_len = 0;
        cs_first = -1;
        guard = 0;
        while (!grant && guard < 2000) begin
            if (cs_wake) begin
                if (cs_first < 0) cs_first = n;
                cs_len++;
            end
            @(negedge clk);
            guard++;
        end
        req = 1'b0;
        chk(n == exp_g, wake ? "R5 grant edge after wake" : "R2 grant edge after gap", n, exp_g);
        chk(cs_len == exp_len, "R3 R4 wake pulse length", cs_len, exp_len);
        if (wake) chk(cs_first == m + 1, "R4 wake pulse start", cs_first, m + 1);
        chk(cs_wake == 1'b0, "R4 no wake during grant", cs_wake, 0);
        dead_ms = (exp_g - 1) / CPM + SLEEP;   // R6 model
        @(negedge clk);
        chk(grant == 1'b0, "R7 grant single cycle", grant, 0);
        repeat (xfer_cyc) begin
            chk(busy == 1'b1, "R8 busy during transfer", busy, 1);
            @(negedge clk);
        end
        done = 1'b1;
        last_ms = n / CPM;
        @(negedge clk);
        done = 1'b0;
        chk(busy == 1'b0, "R8 busy drops after done", busy, 0);
        @(negedge clk);
        chk(grant == 1'b0 && busy == 1'b0, "R10 no second grant", int'(grant) + int'(busy), 0);
        // one idle cycle was consumed above
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(grant == 1'b0, "R1 grant low in reset", grant, 0);
        chk(busy == 1'b0, "R1 busy low in reset", busy, 0);
        chk(cs_wake == 1'b0, "R1 wake low in reset", cs_wake, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && cs_wake == 1'b0, "R1 idle after release", int'(busy) + int'(cs_wake), 0);

        // R1: first request wakes; R2 gap from reset time
        txn(0, 2, 1'b0);
        // R2/R3: back-to-back, no wake
        txn(0, 1, 1'b0);
        // R9: done while idle is ignored
        repeat (3) @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk(busy == 1'b0, "R9 idle done leaves busy low", busy, 0);
        txn(0, 1, 1'b0);
        // Sweep idle spans across gap phase and sleep deadline boundary
        for (int idle = 0; idle <= SLEEP * CPM + 12; idle += 3) begin
            txn(idle, 1 + (idle % 3), 1'b0);
        end
        // R10: request held through waits
        for (int idle = 0; idle <= SLEEP * CPM + 8; idle += 11) begin
            txn(idle, 2, 1'b1);
        end
        // Long idle guarantees wake, held request
        txn(SLEEP * CPM + 20, 1, 1'b1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", n, 0);
        finish_run();
    end

endmodule